// File: doc/BRIEF.md
# Bitplane Fetch Sequencer

This block decides, cycle by cycle within one raster line, when a planar video controller fetches bitplane data and which plane each fetch serves. It compares the incoming horizontal position with a programmable fetch-start and fetch-stop position. Between those positions it runs an eight-slot block sequencer. Each slot of a block belongs to one plane or to no plane, and a plane is fetched only if its index is below the programmed plane count. When the block that completes at or after the stop position ends, the block issues one modulo strobe. The pointer logic outside the block then adds the odd or even modulo to each plane pointer.

Bitplane DMA is switched on and off through a set/clear control word. Switching off does not take effect at once: fetching continues for a short cooldown, and then the sequencer freezes in mid-line. If it is switched back on later in the same line, the slot counter restarts from zero and the stop position counts as already passed. One block is then fetched, or two blocks if the freeze came exactly at the end of a block. The freeze at a block end also produces an extra, early modulo strobe. After that the rest of the line is blank. Every line start returns the sequencer to idle.

All strobes leave through a delay line, so a fetch decision shows at the outputs a fixed number of cycles after the decision.

Top module: `bpl_fetch_seq`

## Requirements
- R1: During reset and in the first cycle after reset, fetch_req, ptr_inc and mod_add are all zero.
- R2: A control write changes the DMA enable only when ctl_wdata bit 8 is 1. In that case bit 15 = 1 sets the enable and bit 15 = 0 clears it. So 0x8100 enables, 0x0100 disables, and writes with bit 8 = 0 (for example 0x8000 or 0x0000) have no effect.
- R3: With DMA on at the cycle where hpos equals ddf_start, slot k (k = 0, 1, …) is decided at hpos = ddf_start + 1 + k. The slot counter is k mod 8, and the counter-to-plane map is 0:none, 1:plane 3, 2:plane 5, 3:plane 1, 4:none, 5:plane 2, 6:plane 4, 7:plane 0. A plane is fetched only if its index is below plane_count. The number of blocks is ceil((ddf_stop − ddf_start) / 8).
- R4: Every fetch_req pulse carries fetch_plane, and ptr_inc is one-hot at bit fetch_plane (the pointer of that plane advances by 2). ptr_inc is zero when there is no fetch.
- R5: Exactly one mod_add pulse follows the last block of a normal line, decided in the cycle after that block's final slot. mod_add never coincides with fetch_req and never lasts two cycles.
- R6: Outputs appear LEAD (default 2) cycles after the decision cycle.
- R7: After a clearing write in cycle W, slots are still processed in cycles W+1 to W+4. From W+5 on, the sequencer is frozen.
- R8: A setting write in cycle E while frozen restarts the slot counter at zero in cycle E+2 with the stop treated as passed. One block is then fetched, followed by mod_add and a blank rest of line.
- R9: If the last processed slot before the freeze has counter value 7, an early mod_add is issued in the next cycle. A later re-enable in the same line then fetches two blocks, followed by a second mod_add.
- R10: With plane_count = 0, no fetch_req and no mod_add are issued.
- R11: At hpos = 0 the sequencer returns to idle. A line frozen by a disable does not carry its state into the next line.
- R12: If DMA is off in the cycle where hpos equals ddf_start, the line issues no fetch and no modulo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | HPOS_W | Horizontal position, 0 at line start |
| ddf_start | input | HPOS_W | Fetch start position |
| ddf_stop | input | HPOS_W | Fetch stop position |
| plane_count | input | CNT_W | Number of active planes |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word (bit 15 set/clear, bit 8 bitplane DMA) |
| fetch_req | output | 1 | Bitplane fetch request |
| fetch_plane | output | PIDX_W | Plane served by the fetch |
| ptr_inc | output | NPLANES | One-hot pointer-advance strobe |
| mod_add | output | 1 | Add modulo to all plane pointers |

## Verification
If a state or slot counter goes wrong, it shows at the ports LEAD cycles later. It appears as a fetch on the wrong plane, a missing or extra block, or a modulo strobe in the wrong cycle. A lost freeze or restart changes the number of fetches in the line by at least one block, and an early-modulo error doubles or drops a mod_add pulse. Because every line start forces idle, a corrupted state can spoil at most the rest of its own line. The next line's counts and timing show whether the recovery worked.

// File: rtl/bpl_fetch_pkg.sv
package bpl_fetch_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_FETCH = 3'd1,
    SQ_EMOD  = 3'd2,
    SQ_HALT  = 3'd3,
    SQ_MOD   = 3'd4,
    SQ_DONE  = 3'd5
  } seq_state_e;

  localparam int SLOT_BITS   = 3;
  localparam int CTL_SET_BIT = 15;
  localparam int CTL_BPL_BIT = 8;

  // {valid, plane index} for each position of the eight-slot block
  function automatic logic [3:0] slot_plane(input logic [SLOT_BITS-1:0] c);
    logic [3:0] r;
    case (c)
      3'd1:    r = {1'b1, 3'd3};
      3'd2:    r = {1'b1, 3'd5};
      3'd3:    r = {1'b1, 3'd1};
      3'd5:    r = {1'b1, 3'd2};
      3'd6:    r = {1'b1, 3'd4};
      3'd7:    r = {1'b1, 3'd0};
      default: r = 4'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bpl_dma_gate.sv
module bpl_dma_gate #(
  parameter int COOL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic set_bit,
  input  logic bpl_bit,
  output logic run,
  output logic last_run
);
  localparam int CW = $clog2(COOL + 1);

  logic          en;
  logic [CW-1:0] cool;
  logic          do_set, do_clr;

  assign do_set = wr && bpl_bit && set_bit;
  assign do_clr = wr && bpl_bit && !set_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      cool <= '0;
    end else if (do_set) begin
      en   <= 1'b1;
      cool <= '0;
    end else if (do_clr && en) begin
      en   <= 1'b0;
      cool <= CW'(COOL);
    end else if (cool != '0) begin
      cool <= cool - 1'b1;
    end
  end

  assign run      = en || (cool != '0);
  assign last_run = !en && (cool == CW'(1)) && !do_set;

endmodule

// File: rtl/bpl_seq_core.sv
module bpl_seq_core
  import bpl_fetch_pkg::*;
#(
  parameter int HPOS_W = 9,
  parameter int CNT_W  = 3,
  parameter int PIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W-1:0] ddf_start,
  input  logic [HPOS_W-1:0] ddf_stop,
  input  logic [CNT_W-1:0]  plane_count,
  input  logic              run,
  input  logic              last_run,
  output logic              dec_fetch,
  output logic [PIDX_W-1:0] dec_plane,
  output logic              dec_mod,
  output seq_state_e        state
);
  logic [SLOT_BITS-1:0] cnt;
  logic                 stop_passed;
  logic                 extra_blk;
  logic                 stop_now;
  logic                 blk_end;
  logic [3:0]           slot;

  assign stop_now = stop_passed || (hpos == ddf_stop);
  assign blk_end  = (cnt == {SLOT_BITS{1'b1}});
  assign slot     = slot_plane(cnt);

  always_ff @(posedge clk) begin
    if (rst || hpos == '0) begin
      state       <= SQ_IDLE;
      cnt         <= '0;
      stop_passed <= 1'b0;
      extra_blk   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (hpos == ddf_start && run && plane_count != '0) begin
            state <= SQ_FETCH;
            cnt   <= '0;
          end
        end
        SQ_FETCH: begin
          if (!run) begin
            state     <= SQ_HALT;
            extra_blk <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if (hpos == ddf_stop) stop_passed <= 1'b1;
            if (blk_end) begin
              if (stop_now) begin
                if (extra_blk) extra_blk <= 1'b0;
                else           state     <= SQ_MOD;
              end else if (last_run) begin
                state <= SQ_EMOD;
              end
            end
          end
        end
        SQ_EMOD: begin
          state     <= SQ_HALT;
          extra_blk <= 1'b1;
        end
        SQ_HALT: begin
          if (hpos == ddf_stop) stop_passed <= 1'b1;
          if (run) begin
            state       <= SQ_FETCH;
            cnt         <= '0;
            stop_passed <= 1'b1;
          end
        end
        SQ_MOD:  state <= SQ_DONE;
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    dec_fetch = (state == SQ_FETCH) && run && slot[3] &&
                (int'(slot[2:0]) < int'(plane_count));
    dec_plane = PIDX_W'(slot[2:0]);
    dec_mod   = (state == SQ_MOD) || (state == SQ_EMOD);
  end

endmodule

// File: rtl/bpl_out_pipe.sv
module bpl_out_pipe #(
  parameter int LEAD    = 2,
  parameter int NPLANES = 6,
  parameter int PIDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               d_fetch,
  input  logic [PIDX_W-1:0]  d_plane,
  input  logic               d_mod,
  output logic               q_fetch,
  output logic [PIDX_W-1:0]  q_plane,
  output logic [NPLANES-1:0] q_inc,
  output logic               q_mod
);
  logic               st_fetch [LEAD];
  logic [PIDX_W-1:0]  st_plane [LEAD];
  logic [NPLANES-1:0] st_inc   [LEAD];
  logic               st_mod   [LEAD];
  logic [NPLANES-1:0] d_inc;

  assign d_inc = d_fetch ? (NPLANES'(1) << d_plane) : '0;

  for (genvar g = 0; g < LEAD; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          st_fetch[0] <= 1'b0;
          st_plane[0] <= '0;
          st_inc[0]   <= '0;
          st_mod[0]   <= 1'b0;
        end else begin
          st_fetch[0] <= d_fetch;
          st_plane[0] <= d_plane;
          st_inc[0]   <= d_inc;
          st_mod[0]   <= d_mod;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          st_fetch[g] <= 1'b0;
          st_plane[g] <= '0;
          st_inc[g]   <= '0;
          st_mod[g]   <= 1'b0;
        end else begin
          st_fetch[g] <= st_fetch[g-1];
          st_plane[g] <= st_plane[g-1];
          st_inc[g]   <= st_inc[g-1];
          st_mod[g]   <= st_mod[g-1];
        end
      end
    end
  end

  assign q_fetch = st_fetch[LEAD-1];
  assign q_plane = st_plane[LEAD-1];
  assign q_inc   = st_inc[LEAD-1];
  assign q_mod   = st_mod[LEAD-1];

endmodule

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq
  import bpl_fetch_pkg::*;
#(
  parameter int HPOS_W  = 9,
  parameter int NPLANES = 6,
  parameter int LEAD    = 2,
  parameter int COOL    = 4,
  localparam int CNT_W  = $clog2(NPLANES + 1),
  localparam int PIDX_W = $clog2(NPLANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HPOS_W-1:0]  hpos,
  input  logic [HPOS_W-1:0]  ddf_start,
  input  logic [HPOS_W-1:0]  ddf_stop,
  input  logic [CNT_W-1:0]   plane_count,
  input  logic               ctl_wr,
  input  logic [15:0]        ctl_wdata,
  output logic               fetch_req,
  output logic [PIDX_W-1:0]  fetch_plane,
  output logic [NPLANES-1:0] ptr_inc,
  output logic               mod_add
);
  logic              run, last_run;
  logic              dec_fetch, dec_mod;
  logic [PIDX_W-1:0] dec_plane;
  seq_state_e        seq_state;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[14:9], ctl_wdata[7:0]};

  bpl_dma_gate #(.COOL(COOL)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .set_bit  (ctl_wdata[CTL_SET_BIT]),
    .bpl_bit  (ctl_wdata[CTL_BPL_BIT]),
    .run      (run),
    .last_run (last_run)
  );

  bpl_seq_core #(.HPOS_W(HPOS_W), .CNT_W(CNT_W), .PIDX_W(PIDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .hpos        (hpos),
    .ddf_start   (ddf_start),
    .ddf_stop    (ddf_stop),
    .plane_count (plane_count),
    .run         (run),
    .last_run    (last_run),
    .dec_fetch   (dec_fetch),
    .dec_plane   (dec_plane),
    .dec_mod     (dec_mod),
    .state       (seq_state)
  );

  bpl_out_pipe #(.LEAD(LEAD), .NPLANES(NPLANES), .PIDX_W(PIDX_W)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .d_fetch (dec_fetch),
    .d_plane (dec_plane),
    .d_mod   (dec_mod),
    .q_fetch (fetch_req),
    .q_plane (fetch_plane),
    .q_inc   (ptr_inc),
    .q_mod   (mod_add)
  );

endmodule

// File: rtl/bpl_fetch_seq_chk.sv
module bpl_fetch_seq_chk
  import bpl_fetch_pkg::*;
#(
  parameter int HPOS_W  = 9,
  parameter int NPLANES = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [HPOS_W-1:0]  hpos,
  input logic               fetch_req,
  input logic [NPLANES-1:0] ptr_inc,
  input logic               mod_add,
  input seq_state_e         seq_state
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fetch_req && !mod_add && ptr_inc == '0));

  a_r4_inc_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr_inc) && (!fetch_req -> ptr_inc == '0));

  a_r5_mod_single: assert property (@(posedge clk) disable iff (rst)
    mod_add |=> !mod_add);

  a_r5_mod_excl: assert property (@(posedge clk) disable iff (rst)
    !(mod_add && fetch_req));

  a_r11_line_clear: assert property (@(posedge clk) disable iff (rst)
    (hpos == '0) |=> (seq_state == SQ_IDLE));

endmodule

bind bpl_fetch_seq bpl_fetch_seq_chk #(.HPOS_W(HPOS_W), .NPLANES(NPLANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hpos      (hpos),
  .fetch_req (fetch_req),
  .ptr_inc   (ptr_inc),
  .mod_add   (mod_add),
  .seq_state (seq_state)
);

// File: tb/bpl_fetch_seq_tb.sv
`timescale 1ns/1ps
module bpl_fetch_seq_tb;
  localparam int LINE = 228;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] hpos = '0, ddf_start = '0, ddf_stop = '0;
  logic [2:0] plane_count = '0;
  logic       ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic       fetch_req, mod_add;
  logic [2:0] fetch_plane;
  logic [5:0] ptr_inc;

  int n_checks = 0, n_fail = 0;
  int n_fetch, n_mod, first_fetch, first_mod, last_mod, bad;
  bit done = 0;

  bpl_fetch_seq u_dut (
    .clk(clk), .rst(rst), .hpos(hpos), .ddf_start(ddf_start), .ddf_stop(ddf_stop),
    .plane_count(plane_count), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fetch_req(fetch_req), .fetch_plane(fetch_plane), .ptr_inc(ptr_inc), .mod_add(mod_add)
  );

  always #2.5 clk = ~clk;

  // rows: start, stop, planes, fetches, mods, first fetch sample, modulo sample
  localparam int T_S [6] = '{32, 24, 40, 56, 48, 32};
  localparam int T_P [6] = '{64, 56, 60, 208, 50, 64};
  localparam int T_C [6] = '{4, 6, 1, 2, 3, 0};
  localparam int T_F [6] = '{16, 24, 3, 38, 3, 0};
  localparam int T_M [6] = '{1, 1, 1, 1, 1, 0};
  localparam int T_FF[6] = '{36, 28, 50, 62, 54, -1};
  localparam int T_MI[6] = '{67, 59, 67, 211, 59, -1};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_line(input int s, input int p, input int c,
                          input int wh0, input int wd0, input int wh1, input int wd1);
    n_fetch = 0; n_mod = 0; first_fetch = -1; first_mod = -1; last_mod = -1; bad = 0;
    for (int h = 0; h < LINE; h++) begin
      @(negedge clk);
      if (fetch_req) begin
        n_fetch++;
        if (first_fetch < 0) first_fetch = h;
        if (ptr_inc != (6'd1 << fetch_plane) || int'(fetch_plane) >= c) bad++;
      end
      if (mod_add) begin
        n_mod++;
        if (first_mod < 0) first_mod = h;
        last_mod = h;
      end
      hpos        = 9'(h);
      ddf_start   = 9'(s);
      ddf_stop    = 9'(p);
      plane_count = 3'(c);
      ctl_wr      = (h == wh0) || (h == wh1);
      ctl_wdata   = (h == wh0) ? 16'(wd0) : 16'(wd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 fetch_req in reset", int'(fetch_req), 0);
    check("R1 mod_add in reset", int'(mod_add), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ptr_inc after reset", int'(ptr_inc), 0);
    check("R1 fetch_req after reset", int'(fetch_req), 0);

    // DMA never enabled; 0x8000 lacks bit 8 and must not enable
    run_line(32, 64, 4, 10, 'h8000, -1, 0);
    check("R12 fetches with DMA off", n_fetch, 0);
    check("R2 0x8000 ignored, modulo", n_mod, 0);

    // enable with 0x8100 before start
    run_line(32, 64, 4, 5, 'h8100, -1, 0);
    check("R2 enable by 0x8100 fetches", n_fetch, 16);

    for (int i = 0; i < 6; i++) begin
      string tag;
      run_line(T_S[i], T_P[i], T_C[i], -1, 0, -1, 0);
      tag = (T_C[i] == 0) ? "R10" : "R3";
      check($sformatf("%s fetch count row %0d", tag, i), n_fetch, T_F[i]);
      check($sformatf("R5 modulo count row %0d", i), n_mod, T_M[i]);
      check($sformatf("R6 first fetch sample row %0d", i), first_fetch, T_FF[i]);
      check($sformatf("R5 modulo sample row %0d", i), first_mod, T_MI[i]);
      check($sformatf("R4 strobe/plane errors row %0d", i), bad, 0);
    end

    // 0x0000 has bit 8 clear: no effect while running
    run_line(32, 64, 4, 40, 'h0000, -1, 0);
    check("R2 0x0000 ignored, fetches", n_fetch, 16);

    // off mid-block at 40, on at 80
    run_line(32, 160, 4, 40, 'h0100, 80, 'h8100);
    check("R7 R8 fetches with mid-line off/on", n_fetch, 10);
    check("R8 modulo count", n_mod, 1);
    check("R8 modulo sample", last_mod, 92);

    // off so that last slot completes a block, on at 80
    run_line(32, 160, 4, 44, 'h0100, 80, 'h8100);
    check("R9 fetches two blocks after re-enable", n_fetch, 16);
    check("R9 modulo count", n_mod, 2);
    check("R9 early modulo sample", first_mod, 51);
    check("R9 final modulo sample", last_mod, 100);

    // off with no re-enable, then recover on the next line
    run_line(32, 160, 4, 40, 'h0100, -1, 0);
    check("R7 fetches before freeze", n_fetch, 6);
    check("R7 no modulo when frozen", n_mod, 0);
    run_line(32, 64, 4, 5, 'h8100, -1, 0);
    check("R11 next line fetches", n_fetch, 16);
    check("R11 next line modulo", n_mod, 1);
    check("R11 next line first fetch", first_fetch, 36);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule